// File: doc/BRIEF.md
# Floating-Point Register Bit-Move Unit

This unit carries a raw floating-point bit pattern between the integer register file and the floating-point register file, in either direction, without any arithmetic on the value. A direction input picks the destination: an integer register or a floating-point register. A two-bit mode code picks the operand width and whether a condition nibble is produced. The floating-point register always holds values in 64-bit double form.

In double width the 64 bits pass through unchanged. In single width the unit repacks the value. When the destination is an integer register, it shrinks the double in-register form to a 32-bit single encoding in the low word and zeroes the high word. When the destination is a floating-point register, it expands a 32-bit single encoding taken from the low word of the integer operand into double form.

When the mode asks for a record, the unit also emits a 4-bit condition nibble with a write enable and a field select. The nibble describes the value that was written. The floating-point status register is never read or written. One request may be issued on every clock cycle, and the results appear one cycle after the request.

Top module: `fbm_unit`

## Requirements
- R1: The mode code works as follows: bit 1 selects single width (1) or double width (0), and bit 0 requests a record. `cond_we_o` is high exactly in the cycle after an accepted request whose mode bit 0 is 1.
- R2: In double width, `result_o` equals `src_i` bit for bit in both directions.
- R3: Integer destination, single width: `result_o[63:32]` is zero. `result_o[31:0]` is {src[63], src[62], src[58:52], src[51:29]}, with no rounding.
- R4: Floating-point destination, single width: only `src_i[31:0]` affects the result. The upper 32 bits are ignored.
- R5: Floating-point destination, single width, for a normal single with exponent e (1..254): the double exponent is e+896, the sign is kept, and the 23 fraction bits are placed at the top of the 52-bit fraction with zeros below them.
- R6: Floating-point destination, single width: an all-ones single exponent gives the all-ones double exponent 0x7FF with the fraction (NaN payload) left-aligned. A signed single zero gives a signed double zero.
- R7: Floating-point destination, single width, for a nonzero denormal single: the value is normalised. If the leading one of the fraction is at bit p, the double exponent is 874+p and the fraction bits below that leading one are left-aligned.
- R8: On a record with an integer destination, `cond_sel_o` is 0 and `cond_o` is {LT, GT, EQ, 0}, from a signed compare of the 64-bit result with zero.
- R9: On a record with a floating-point destination, `cond_sel_o` is 1 and `cond_o` is {negative, positive, zero, NaN} for the 64-bit double result. Exactly one of these bits is set; infinities count as negative or positive.
- R10: Outputs are registered with a latency of one cycle. During reset and after it, `valid_o`, `cond_we_o`, `cond_o` and `result_o` are zero until the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Request strobe |
| dir_i | input | 1 | 0: to integer register, 1: to floating-point register |
| mode_i | input | 2 | Bit 1 single width, bit 0 record |
| src_i | input | 64 | Source register value |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Destination register value |
| cond_we_o | output | 1 | Condition nibble write enable |
| cond_sel_o | output | 1 | 0: integer condition field, 1: floating-point condition field |
| cond_o | output | 4 | Condition nibble |

## Verification
In one cycle, a single-width repack and a record can both take effect, so the condition nibble has to describe the repacked value and not the raw source. Mode 3 is driven with random sources and with directed low words: NaN, infinity, signed zero and denormals, placed under random upper words. The nibble and the result are then compared with values the bench derives from the requirements. One case needs special care: a negative upper word with a positive single in the low word must produce a positive nibble.

// File: rtl/fbm_pkg.sv
package fbm_pkg;
    localparam int DBL_W   = 64;
    localparam int SGL_W   = 32;
    localparam int DEXP_W  = 11;
    localparam int SEXP_W  = 8;
    localparam int DFRAC_W = 52;
    localparam int SFRAC_W = 23;
    localparam int FRAC_PAD = DFRAC_W - SFRAC_W;
    localparam int NIB_W   = 4;
    localparam int POS_W   = $clog2(SFRAC_W + 1);
    localparam logic [DEXP_W-1:0] BIAS_DIFF = DEXP_W'(1023 - 127);
    localparam logic [DEXP_W-1:0] DEN_BASE  = DEXP_W'(1023 - 149);

    typedef struct packed {
        logic             valid;
        logic [DBL_W-1:0] result;
        logic             cond_we;
        logic             cond_sel;
        logic [NIB_W-1:0] cond;
    } out_t;
endpackage

// File: rtl/fbm_pack.sv
module fbm_pack
    import fbm_pkg::*;
(
    input  logic               sign_i,
    input  logic               exp_top_i,
    input  logic [SEXP_W-2:0]  exp_low_i,
    input  logic [SFRAC_W-1:0] frac_top_i,
    output logic [SGL_W-1:0]   single_o
);
    always_comb begin
        single_o = {sign_i, exp_top_i, exp_low_i, frac_top_i};
    end
endmodule

// File: rtl/fbm_expand.sv
module fbm_expand
    import fbm_pkg::*;
(
    input  logic [SGL_W-1:0] single_i,
    output logic [DBL_W-1:0] double_o
);
    logic               sgn;
    logic [SEXP_W-1:0]  exp_s;
    logic [SFRAC_W-1:0] frac_s;
    logic [POS_W-1:0]   lead;
    logic [SFRAC_W:0]   norm;
    logic [DEXP_W-1:0]  exp_d;
    logic [SFRAC_W-1:0] frac_d;

    assign sgn    = single_i[SGL_W-1];
    assign exp_s  = single_i[SGL_W-2 -: SEXP_W];
    assign frac_s = single_i[SFRAC_W-1:0];

    always_comb begin
        lead = '0;
        for (int i = 0; i < SFRAC_W; i++) begin
            if (frac_s[i]) lead = POS_W'(i);
        end
        norm = {1'b0, frac_s} << (POS_W'(SFRAC_W) - lead);
    end

    always_comb begin
        if (&exp_s) begin
            exp_d  = '1;
            frac_d = frac_s;
        end else if (exp_s == '0) begin
            if (frac_s == '0) begin
                exp_d  = '0;
                frac_d = '0;
            end else begin
                exp_d  = DEN_BASE + DEXP_W'(lead);
                frac_d = norm[SFRAC_W-1:0];
            end
        end else begin
            exp_d  = DEXP_W'(exp_s) + BIAS_DIFF;
            frac_d = frac_s;
        end
        double_o = {sgn, exp_d, frac_d, {FRAC_PAD{1'b0}}};
    end
endmodule

// File: rtl/fbm_cond.sv
module fbm_cond
    import fbm_pkg::*;
(
    input  logic [DBL_W-1:0] value_i,
    output logic [NIB_W-1:0] int_nib_o,
    output logic [NIB_W-1:0] flt_nib_o
);
    logic zero_int, exp_ones, frac_zero, mag_zero, is_nan;

    assign zero_int  = (value_i == '0);
    assign exp_ones  = &value_i[DBL_W-2 -: DEXP_W];
    assign frac_zero = (value_i[DFRAC_W-1:0] == '0);
    assign mag_zero  = (value_i[DBL_W-2:0] == '0);
    assign is_nan    = exp_ones && !frac_zero;

    always_comb begin
        int_nib_o = {value_i[DBL_W-1], !value_i[DBL_W-1] && !zero_int, zero_int, 1'b0};
        if (is_nan)
            flt_nib_o = 4'b0001;
        else if (mag_zero)
            flt_nib_o = 4'b0010;
        else if (value_i[DBL_W-1])
            flt_nib_o = 4'b1000;
        else
            flt_nib_o = 4'b0100;
    end
endmodule

// File: rtl/fbm_unit.sv
module fbm_unit
    import fbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             dir_i,
    input  logic [1:0]       mode_i,
    input  logic [DBL_W-1:0] src_i,
    output logic             valid_o,
    output logic [DBL_W-1:0] result_o,
    output logic             cond_we_o,
    output logic             cond_sel_o,
    output logic [NIB_W-1:0] cond_o
);
    out_t out_d, out_q;

    logic [SGL_W-1:0] packed_single;
    logic [DBL_W-1:0] expanded;
    logic [DBL_W-1:0] res_c;
    logic [NIB_W-1:0] int_nib, flt_nib;

    fbm_pack i_pack (
        .sign_i     (src_i[DBL_W-1]),
        .exp_top_i  (src_i[DBL_W-2]),
        .exp_low_i  (src_i[DFRAC_W +: SEXP_W-1]),
        .frac_top_i (src_i[DFRAC_W-1 -: SFRAC_W]),
        .single_o   (packed_single)
    );

    fbm_expand i_expand (
        .single_i (src_i[SGL_W-1:0]),
        .double_o (expanded)
    );

    fbm_cond i_cond (
        .value_i   (res_c),
        .int_nib_o (int_nib),
        .flt_nib_o (flt_nib)
    );

    always_comb begin
        if (!mode_i[1])
            res_c = src_i;
        else if (dir_i)
            res_c = expanded;
        else
            res_c = {{(DBL_W-SGL_W){1'b0}}, packed_single};
    end

    always_comb begin
        out_d         = out_q;
        out_d.valid   = valid_i;
        out_d.cond_we = valid_i && mode_i[0];
        if (valid_i) begin
            out_d.result = res_c;
            if (mode_i[0]) begin
                out_d.cond_sel = dir_i;
                out_d.cond     = dir_i ? flt_nib : int_nib;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign valid_o    = out_q.valid;
    assign result_o   = out_q.result;
    assign cond_we_o  = out_q.cond_we;
    assign cond_sel_o = out_q.cond_sel;
    assign cond_o     = out_q.cond;
endmodule

// File: rtl/fbm_unit_chk.sv
module fbm_unit_chk
    import fbm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             valid_i,
    input logic             dir_i,
    input logic [1:0]       mode_i,
    input logic [DBL_W-1:0] src_i,
    input logic             valid_o,
    input logic [DBL_W-1:0] result_o,
    input logic             cond_we_o,
    input logic             cond_sel_o,
    input logic [NIB_W-1:0] cond_o
);
    AST_RECORD_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mode_i[0]) |=> cond_we_o);  // R1
    AST_NO_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && mode_i[0]) |=> !cond_we_o);  // R1
    AST_DOUBLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !mode_i[1]) |=> (result_o == $past(src_i)));  // R2
    AST_SINGLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !dir_i && mode_i[1]) |=> (result_o[DBL_W-1:SGL_W] == '0));  // R3
    AST_INT_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_we_o && !cond_sel_o) |-> (!cond_o[0] && $countones(cond_o) == 1));  // R8
    AST_FLT_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_we_o && cond_sel_o) |-> $onehot0(cond_o) && (cond_o != '0));  // R9
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);  // R10
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && !cond_we_o && result_o == '0));  // R10
endmodule

bind fbm_unit fbm_unit_chk i_fbm_unit_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_i),
    .dir_i      (dir_i),
    .mode_i     (mode_i),
    .src_i      (src_i),
    .valid_o    (valid_o),
    .result_o   (result_o),
    .cond_we_o  (cond_we_o),
    .cond_sel_o (cond_sel_o),
    .cond_o     (cond_o)
);

// File: tb/test_fbm_unit.sv
module test_fbm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        dir_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [63:0] src_i = '0;
    logic        valid_o;
    logic [63:0] result_o;
    logic        cond_we_o;
    logic        cond_sel_o;
    logic [3:0]  cond_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fbm_unit i_fbm_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .dir_i(dir_i),
        .mode_i(mode_i), .src_i(src_i), .valid_o(valid_o),
        .result_o(result_o), .cond_we_o(cond_we_o),
        .cond_sel_o(cond_sel_o), .cond_o(cond_o)
    );

    function automatic logic [63:0] ref_expand(input logic [31:0] w);
        logic [23:0] m;
        int sh;
        if (w[30:23] == 8'hFF) return {w[31], 11'h7FF, w[22:0], 29'b0};
        if (w[30:0] == '0) return {w[31], 63'b0};
        if (w[30:23] == 8'h00) begin
            m = {1'b0, w[22:0]};
            sh = 0;
            while (!m[23]) begin m = m << 1; sh++; end
            return {w[31], 11'(897 - sh), m[22:0], 29'b0};
        end
        return {w[31], 11'(int'(w[30:23]) + 896), w[22:0], 29'b0};
    endfunction

    function automatic logic [63:0] ref_result(input logic d, input logic [1:0] m, input logic [63:0] s);
        if (!m[1]) return s;
        if (d) return ref_expand(s[31:0]);
        return {32'b0, s[63], s[62], s[58:52], s[51:29]};
    endfunction

    function automatic logic [3:0] ref_cond(input logic d, input logic [63:0] r);
        if (!d) begin
            if ($signed(r) < 0) return 4'b1000;
            if (r == 0) return 4'b0010;
            return 4'b0100;
        end
        if (r[62:52] == 11'h7FF && r[51:0] != 0) return 4'b0001;
        if (r[62:0] == 0) return 4'b0010;
        return r[63] ? 4'b1000 : 4'b0100;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic d, input logic [1:0] m, input logic [63:0] s, input string req);
        logic [63:0] er;
        @(negedge clk);
        valid_i = 1'b1; dir_i = d; mode_i = m; src_i = s;
        @(negedge clk);
        valid_i = 1'b0;
        er = ref_result(d, m, s);
        check({req, " result"}, result_o, er);
        check("R10 valid", {63'b0, valid_o}, 64'd1);
        check("R1 cond_we", {63'b0, cond_we_o}, {63'b0, m[0]});
        if (m[0]) begin
            check(d ? "R9 sel" : "R8 sel", {63'b0, cond_sel_o}, {63'b0, d});
            check(d ? "R9 nibble" : "R8 nibble", {60'b0, cond_o}, {60'b0, ref_cond(d, er)});
        end
    endtask

    initial begin
        #1_600_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lw;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R10 reset valid", {63'b0, valid_o}, 64'd0);
        check("R10 reset cond_we", {63'b0, cond_we_o}, 64'd0);
        check("R10 reset result", result_o, 64'd0);
        rst_n = 1'b1;

        run(1'b0, 2'd0, 64'hC00F_1234_5678_9ABC, "R2");
        run(1'b1, 2'd1, 64'h8000_0000_0000_0000, "R2");
        run(1'b0, 2'd2, 64'hBFF8_0000_1234_5678, "R3");
        run(1'b0, 2'd3, 64'h7FF8_0000_0000_0001, "R3");
        run(1'b1, 2'd3, 64'hFFFF_FFFF_3F80_0000, "R4");
        run(1'b1, 2'd2, 64'h0000_0000_C049_0FDB, "R5");
        run(1'b1, 2'd3, 64'h1234_5678_7FC0_0001, "R6");
        run(1'b1, 2'd3, 64'h0000_0000_FF80_0000, "R6");
        run(1'b1, 2'd3, 64'hAAAA_AAAA_8000_0000, "R6");
        run(1'b1, 2'd3, 64'h0000_0000_0000_0001, "R7");
        run(1'b1, 2'd3, 64'h0000_0000_807F_FFFF, "R7");
        run(1'b0, 2'd1, 64'h0000_0000_0000_0000, "R8");
        run(1'b0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, "R8");

        for (int k = 0; k < 400; k++) begin
            lw = $urandom;
            case ($urandom_range(0, 3))
                0: lw[30:23] = 8'h00;
                1: lw[30:23] = 8'hFF;
                default: ;
            endcase
            run(1'($urandom), 2'($urandom), {32'($urandom), lw}, "R4");
        end

        @(negedge clk);
        check("R1 idle cond_we", {63'b0, cond_we_o}, 64'd0);
        check("R10 idle valid", {63'b0, valid_o}, 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule